// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Generator

This block produces the common-terminal and segment-terminal drive codes for a passive, time-multiplexed LCD panel driven at 1/3 bias. Each terminal output is a 2-bit level code. An analog stage outside the block turns each code into a voltage: 0 is GND, 1 is one third of the panel voltage, 2 is two thirds, and 3 is the full panel voltage. The panel can use one to four common terminals, chosen by a duty select. The common terminals are scanned one slot at a time. In each slot the segment outputs show the pixel bits that belong to the active common.

A prescaled tick input sets the pace. Display data comes from a register-file input and is copied into an internal latch at frame boundaries. At each latch a sticky frame flag is raised, and software clears it with a write-one strobe. There are two waveform styles. In the default style the polarity flips halfway through every slot, so each frame is DC-balanced by itself. In the low-power style the polarity is held for a whole frame and flipped on the next frame, so the outputs toggle less. Because only a pair of identical frames is DC-free in that style, data is latched and the flag is raised only once per frame pair. A change of style waits for the next latch boundary.

Top module: `lcd_wave_gen`

## Requirements
- R1: With polarity 0, the active common is at code 3 and the inactive used commons are at code 1. A segment whose pixel is on is at code 0, and a segment whose pixel is off is at code 2. With polarity 1 these are mirrored: active common 0, inactive commons 2, on segment 3, off segment 1.
- R2: A phase lasts PHASE_TICKS ticks. A slot is two phases. Slots serve the commons 0 up to dutySel in order, and the frame wraps after common dutySel.
- R3: In the default style, polarity is 0 in the first phase of every slot and 1 in the second phase.
- R4: In the low-power style, polarity is 0 for the whole first frame after a latch and 1 for the whole second frame.
- R5: The segments show the latched bit segData[slot*NUM_SEG + j]. The latch loads at the end of every frame in the default style, and at the end of every second frame in the low-power style. While the display is disabled, the latch follows segData on every cycle.
- R6: frameIrq is set on the same edge that a frame latch happens. It stays set until irqClear is high. If a set and a clear arrive on the same edge, the set wins.
- R7: A change of lowPower takes effect only at a latch boundary, or on any cycle while the display is disabled. A frame pair is never split.
- R8: Commons above dutySel are held at code 0.
- R9: While enable is 0, every output is code 0, and the tick, phase, slot and frame-pair counters return to zero.
- R10: For any used common, the pixel difference |SEG - COM| is 3 when that common is active and the pixel is on. Otherwise it is 1.
- R11: Reset clears the frame flag and the data latch, and it selects the default style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Display enable |
| tick | input | 1 | Prescaled timing strobe |
| lowPower | input | 1 | Requests the low-power waveform style |
| dutySel | input | 2 | Index of the highest used common (0 to 3) |
| segData | input | 4*NUM_SEG | Display bits, common-major |
| irqClear | input | 1 | Write-one-to-clear strobe for the frame flag |
| comLevel | output | 8 | Level codes of commons 0 to 3, 2 bits each |
| segLevel | output | 2*NUM_SEG | Level codes of the segments, 2 bits each |
| frameIrq | output | 1 | Sticky frame-latch flag |

## Verification
The hardest case to reach is a lowPower change that lands between the two frames of a low-power pair. The mode must not switch there, and the flag must stay quiet until the pair ends. The stimulus reaches this case by flipping lowPower at random cycles over long low-power runs with uneven tick spacing, so many flips fall inside pairs. Other stimulus windows shrink dutySel during a frame and clear the flag on the same cycle it is set.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;
  localparam int COM_MAX = 4;
  localparam int SLOT_W  = 2;

  typedef enum logic [1:0] {
    LVL_GND   = 2'd0,
    LVL_LOW   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_FULL  = 2'd3
  } level_e;

  typedef struct packed {
    logic              run;
    logic              pol;
    logic [SLOT_W-1:0] slot;
    logic              latch;
    logic              irqSet;
  } ctrl_t;
endpackage

// File: rtl/lcd_wave_ctrl.sv
module lcd_wave_ctrl
  import lcd_wave_pkg::*;
#(
  parameter int PHASE_TICKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        tick,
  input  logic        lowPower,
  input  logic [1:0]  dutySel,
  output ctrl_t       ctrl
);
  localparam int TW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(PHASE_TICKS - 1);

  logic [TW-1:0]     tickCnt;
  logic              phase;
  logic [SLOT_W-1:0] slot;
  logic              frameOdd;
  logic              lpActive;

  logic phaseEnd, slotEnd, frameEnd, pairDone;

  assign phaseEnd = enable && tick && (tickCnt == LAST_TICK);
  assign slotEnd  = phaseEnd && phase;
  assign frameEnd = slotEnd && (slot >= dutySel);
  assign pairDone = frameEnd && (!lpActive || frameOdd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tickCnt  <= '0;
      phase    <= 1'b0;
      slot     <= '0;
      frameOdd <= 1'b0;
      lpActive <= 1'b0;
    end else if (!enable) begin
      tickCnt  <= '0;
      phase    <= 1'b0;
      slot     <= '0;
      frameOdd <= 1'b0;
      lpActive <= lowPower;
    end else if (tick) begin
      tickCnt <= phaseEnd ? '0 : tickCnt + 1'b1;
      if (phaseEnd) phase <= ~phase;
      if (frameEnd) begin
        slot <= '0;
        if (pairDone) begin
          frameOdd <= 1'b0;
          lpActive <= lowPower;
        end else begin
          frameOdd <= 1'b1;
        end
      end else if (slotEnd) begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.run    = enable;
    ctrl.pol    = lpActive ? frameOdd : phase;
    ctrl.slot   = slot;
    ctrl.latch  = !enable || pairDone;
    ctrl.irqSet = pairDone;
  end
endmodule

// File: rtl/lcd_wave_dp.sv
module lcd_wave_dp
  import lcd_wave_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrl_t                       ctrl,
  input  logic [1:0]                  dutySel,
  input  logic [COM_MAX*NUM_SEG-1:0]  segData,
  input  logic                        irqClear,
  output logic [2*COM_MAX-1:0]        comLevel,
  output logic [2*NUM_SEG-1:0]        segLevel,
  output logic                        frameIrq
);
  logic [COM_MAX*NUM_SEG-1:0] shownData;
  logic [NUM_SEG-1:0]         rowBits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shownData <= '0;
      frameIrq  <= 1'b0;
    end else begin
      if (ctrl.latch) shownData <= segData;
      if (ctrl.irqSet)     frameIrq <= 1'b1;
      else if (irqClear)   frameIrq <= 1'b0;
    end
  end

  assign rowBits = shownData[ctrl.slot*NUM_SEG +: NUM_SEG];

  for (genvar c = 0; c < COM_MAX; c++) begin : g_com
    always_comb begin
      if (!ctrl.run || (c > int'(dutySel)))
        comLevel[2*c +: 2] = LVL_GND;
      else if (c == int'(ctrl.slot))
        comLevel[2*c +: 2] = ctrl.pol ? LVL_GND : LVL_FULL;
      else
        comLevel[2*c +: 2] = ctrl.pol ? LVL_HIGH : LVL_LOW;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_comb begin
      if (!ctrl.run)
        segLevel[2*s +: 2] = LVL_GND;
      else if (rowBits[s])
        segLevel[2*s +: 2] = ctrl.pol ? LVL_FULL : LVL_GND;
      else
        segLevel[2*s +: 2] = ctrl.pol ? LVL_LOW : LVL_HIGH;
    end
  end
endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lcd_wave_pkg::*;
#(
  parameter int NUM_SEG     = 8,
  parameter int PHASE_TICKS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    tick,
  input  logic                    lowPower,
  input  logic [1:0]              dutySel,
  input  logic [4*NUM_SEG-1:0]    segData,
  input  logic                    irqClear,
  output logic [7:0]              comLevel,
  output logic [2*NUM_SEG-1:0]    segLevel,
  output logic                    frameIrq
);
  ctrl_t ctrl;

  lcd_wave_ctrl #(.PHASE_TICKS(PHASE_TICKS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tick     (tick),
    .lowPower (lowPower),
    .dutySel  (dutySel),
    .ctrl     (ctrl)
  );

  lcd_wave_dp #(.NUM_SEG(NUM_SEG)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .dutySel  (dutySel),
    .segData  (segData),
    .irqClear (irqClear),
    .comLevel (comLevel),
    .segLevel (segLevel),
    .frameIrq (frameIrq)
  );
endmodule

// File: rtl/lcd_wave_gen_chk.sv
module lcd_wave_gen_chk #(
  parameter int NUM_SEG = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [1:0]           dutySel,
  input logic                 irqClear,
  input logic [7:0]           comLevel,
  input logic [2*NUM_SEG-1:0] segLevel,
  input logic                 frameIrq
);
  logic [3:0] comAtFull;
  logic [1:0] pixDiff;
  for (genvar c = 0; c < 4; c++) begin : g_full
    assign comAtFull[c] = (comLevel[2*c +: 2] == 2'd3);
  end
  assign pixDiff = (segLevel[1:0] >= comLevel[1:0]) ? (segLevel[1:0] - comLevel[1:0])
                                                    : (comLevel[1:0] - segLevel[1:0]);

  a_r9_off_gnd: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (comLevel == '0 && segLevel == '0));

  a_r8_unused_gnd: assert property (@(posedge clk) disable iff (!rst_n)
    (dutySel != 2'd3) |-> (comLevel[7:6] == 2'd0));

  a_r1_single_active: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(comAtFull) <= 1);

  a_r10_pixel_mag: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (pixDiff == 2'd1 || pixDiff == 2'd3));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frameIrq && !irqClear) |=> frameIrq);

  a_r6_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!frameIrq && !enable) |=> !frameIrq);
endmodule

bind lcd_wave_gen lcd_wave_gen_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .dutySel  (dutySel),
  .irqClear (irqClear),
  .comLevel (comLevel),
  .segLevel (segLevel),
  .frameIrq (frameIrq)
);

// File: tb/lcd_wave_gen_test.sv
module lcd_wave_gen_test;
  localparam int NS = 8;
  localparam int PT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tick = 1'b0;
  logic lowPower = 1'b0;
  logic [1:0] dutySel = 2'd3;
  logic [4*NS-1:0] segData = '0;
  logic irqClear = 1'b0;
  logic [7:0] comLevel;
  logic [2*NS-1:0] segLevel;
  logic frameIrq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lcd_wave_gen #(.NUM_SEG(NS), .PHASE_TICKS(PT)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .lowPower(lowPower), .dutySel(dutySel), .segData(segData),
    .irqClear(irqClear), .comLevel(comLevel), .segLevel(segLevel),
    .frameIrq(frameIrq)
  );

  // reference state
  int mTick = 0, mPhase = 0, mSlot = 0, mOdd = 0, mLp = 0, mIrq = 0;
  int setsLp = 0, setsDef = 0;
  logic [4*NS-1:0] mData = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mTick = 0; mPhase = 0; mSlot = 0; mOdd = 0; mLp = 0; mIrq = 0; mData = '0;
    end else if (!enable) begin
      mTick = 0; mPhase = 0; mSlot = 0; mOdd = 0; mLp = lowPower; mData = segData;
      if (irqClear) mIrq = 0;
    end else begin
      bit setNow;
      setNow = 0;
      if (tick) begin
        if (mTick == PT - 1) begin
          mTick = 0;
          if (mPhase == 1) begin
            mPhase = 0;
            if (mSlot >= dutySel) begin
              mSlot = 0;
              if (mLp == 0 || mOdd == 1) begin
                setNow = 1;
                if (mLp != 0) setsLp++; else setsDef++;
                mOdd = 0; mData = segData; mLp = lowPower;
              end else mOdd = 1;
            end else mSlot++;
          end else mPhase = 1;
        end else mTick++;
      end
      if (setNow) mIrq = 1;
      else if (irqClear) mIrq = 0;
    end
  end

  function automatic logic [7:0] expCom();
    logic [7:0] r;
    int pol;
    r = '0;
    pol = mLp ? mOdd : mPhase;
    for (int c = 0; c < 4; c++) begin
      if (enable && c <= dutySel) begin
        if (c == mSlot) r[2*c +: 2] = pol ? 2'd0 : 2'd3;
        else            r[2*c +: 2] = pol ? 2'd2 : 2'd1;
      end
    end
    return r;
  endfunction

  function automatic logic [2*NS-1:0] expSeg();
    logic [2*NS-1:0] r;
    int pol;
    r = '0;
    pol = mLp ? mOdd : mPhase;
    for (int s = 0; s < NS; s++) begin
      if (enable) begin
        if (mData[mSlot*NS + s]) r[2*s +: 2] = pol ? 2'd3 : 2'd0;
        else                     r[2*s +: 2] = pol ? 2'd1 : 2'd2;
      end
    end
    return r;
  endfunction

  task automatic compareAll();
    checks++;
    if (comLevel !== expCom()) begin
      errors++;
      $display("FAIL R1 R2 R3 R4 R8 R9 com: actual %h expected %h", comLevel, expCom());
    end
    checks++;
    if (segLevel !== expSeg()) begin
      errors++;
      $display("FAIL R1 R5 R7 R10 seg: actual %h expected %h", segLevel, expSeg());
    end
    checks++;
    if (frameIrq !== mIrq[0]) begin
      errors++;
      $display("FAIL R6 R7 irq: actual %0b expected %0b", frameIrq, mIrq[0]);
    end
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int cyc = 0;
  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    enable = 1'b1;
    segData = 32'hA5C3_0F96;
    @(negedge clk);
    // R11: reset leaves flag low and latch empty
    checkVal("R11 irq", frameIrq, 0);
    checkVal("R11 seg", segLevel, {NS{2'd2}});
    rst_n = 1'b1;
    enable = 1'b0;
    for (int p = 0; p < 9; p++) begin
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        cyc++;
        compareAll();
        case (p)
          0: begin enable = 1; lowPower = 0; dutySel = 3; tick = 1; end
          1: begin dutySel = 2; tick = ($urandom % 2) == 0; end
          2: begin lowPower = 1; dutySel = 3; tick = 1; end
          3: begin tick = ($urandom % 3) != 0; if (($urandom % 53) == 0) lowPower = ~lowPower; end
          4: begin lowPower = 0; dutySel = 0; tick = 1; end
          5: begin tick = 1; if (($urandom % 150) == 0) enable = ~enable;
                   if (($urandom % 40) == 0) lowPower = ~lowPower; end
          6: begin enable = 1; lowPower = 1; dutySel = 1; tick = ($urandom % 2) == 0; end
          7: begin lowPower = 0; tick = 1; if (($urandom % 70) == 0) dutySel = 2'($urandom); end
          default: begin tick = 1; dutySel = 3; lowPower = ($urandom % 300) == 0 ? ~lowPower : lowPower; end
        endcase
        irqClear = (p == 7) ? (frameIrq != 0) : (($urandom % 16) == 0);
        if (($urandom % 23) == 0) segData = {$urandom, $urandom};
      end
    end
    enable = 0;
    @(negedge clk);
    compareAll();
    // R9: disabled -> all outputs ground
    checkVal("R9 com", comLevel, 0);
    checkVal("R9 seg", segLevel, 0);
    // R4 R5: both styles produced latch events over the run
    checkVal("R4 R5 lp sets seen", (setsLp > 10) ? 1 : 0, 1);
    checkVal("R5 default sets seen", (setsDef > 10) ? 1 : 0, 1);
    done = 1;
  end

  initial begin
    int w;
    w = 0;
    while (!done && w < 150000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule